// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Idle-Only Fallback Master

This block decides which of four masters owns a shared single-layer bus in each address phase. Three are real masters (numbers 1, 2 and 3). Number 0 is an internal placeholder that never moves data. The placeholder can be claimed from outside as a pause request. The arbiter also falls back to it whenever no real master may legally own the bus.

The winner is chosen from a fixed ranking. Master 1 serves as the default owner. A master whose transfer is answered with SPLIT is shut out of arbitration until its unsplit input is pulsed. A locked sequence keeps the bus with its owner.

Ownership moves only on a clock edge where the bus ready signal is high. The block returns two registered master numbers: one for the address phase and one for the data phase. These steer the external address and data multiplexers. It also passes the transfer type through to the bus, except that it forces IDLE while the placeholder owns the bus.

Top module: `prio_bus_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the address-phase and data-phase master numbers become 1, `grant_o` becomes 4'b0010, and every split mask and any locked-split hold are cleared.
- R2: Among requesting, unmasked masters, the winner ranks as follows: master 3 first, then master 0 (the placeholder, via `req_i[0]`), then master 2, then master 1.
- R3: When no master is eligible and master 1 is not masked, master 1 is granted whether or not it requests.
- R4: While master 0 owns the address phase, `htrans_o` is 2'b00 (IDLE). Otherwise `htrans_o` equals `htrans_i`.
- R5: At a rising edge with `hready_i` low, the address-phase number, the data-phase number and `grant_o` keep their values.
- R6: At a rising edge with `hready_i` high, the data-phase number takes the previous address-phase number.
- R7: Response codes are OKAY 2'b00, ERROR 2'b01, RETRY 2'b10 and SPLIT 2'b11. When `hready_i` is high and `hresp_i` is 2'b11, the real master named by the data-phase number is masked. A masked master is not granted until its bit of `unsplit_i` is high (bit j stands for master j+1). The other codes mask nothing.
- R8: While `lock_i` is high for the current owner and that owner is not masked, the owner keeps the bus even if a higher-ranked master requests.
- R9: A SPLIT that hits a master whose `lock_i` bit is high grants master 0. Master 0 keeps the bus, regardless of any other request, until that master is unsplit.
- R10: When master 1 is masked and no other master is eligible, master 0 is granted.
- R11: When all three real masters are masked, master 0 is granted even though the real masters request.
- R12: When a SPLIT and an unsplit pulse name the same master in one cycle, the SPLIT wins and the master stays masked.
- R13: `grant_o` is one-hot, with its set bit at the address-phase master number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 4 | Bus requests; bit 0 is the pause request for the placeholder |
| lock_i | input | 4 | Locked-sequence indication per master |
| unsplit_i | input | 3 | Release of a split master; bit j frees master j+1 |
| hready_i | input | 1 | Shared transfer-done signal |
| hresp_i | input | 2 | Shared transfer response of the data phase |
| htrans_i | input | 2 | Transfer type of the multiplexed address phase |
| grant_o | output | 4 | One-hot grant per master |
| addr_mst_o | output | 2 | Number of the address-phase owner |
| data_mst_o | output | 2 | Number of the data-phase owner |
| htrans_o | output | 2 | Transfer type driven to the bus |

## Verification
Two pairs of events can fall on the same edge. The first is a SPLIT answering a locked sequence while a higher-ranked master requests. The vector table produces this by holding master 3's request over a locked transfer of master 2 and then answering SPLIT; the check is that master 0, not master 3, is granted and stays granted until master 2 is unsplit. The second is a SPLIT and an unsplit pulse aimed at master 3 on the same edge. The check is that master 0 takes the bus on that edge and keeps it on the next, which shows master 3's mask survived.

// File: rtl/arb_pkg.sv
// Shared constants for the fixed-priority bus arbiter.
// Assumes four masters where number 0 is the idle-only placeholder.
package arb_pkg;
    localparam int MST_COUNT  = 4;
    localparam int DUMMY_ID   = 0;
    localparam int DEFAULT_ID = 1;

    // Ranking, highest first; the arbiter relies on this order.
    localparam int PRIO_ORDER [MST_COUNT] = '{3, 0, 2, 1};

    typedef enum logic [1:0] {
        RSP_OKAY  = 2'b00,
        RSP_ERROR = 2'b01,
        RSP_RETRY = 2'b10,
        RSP_SPLIT = 2'b11
    } rsp_e;

    localparam logic [1:0] TRN_IDLE = 2'b00;
endpackage

// File: rtl/arb_split_track.sv
// Keeps the split mask per real master and the locked-split hold.
// Presents next-state values so the arbiter decides on the same edge.
// Assumes a SPLIT belongs to the data-phase master and needs hready high.
module arb_split_track #(
    parameter int NM = arb_pkg::MST_COUNT,
    localparam int IW = $clog2(NM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hready_i,
    input  logic [1:0]    hresp_i,
    input  logic [IW-1:0] data_mst_i,
    input  logic [NM-1:0] lock_i,
    input  logic [NM-2:0] unsplit_i,
    output logic [NM-1:0] mask_nxt_o,
    output logic          lkhold_nxt_o
);
    import arb_pkg::*;

    logic [NM-1:0] mask_q;
    logic          lkhold_q;
    logic [IW-1:0] lkmst_q;
    logic [IW-1:0] lkmst_nxt;
    logic          split_ev;

    // Next mask and locked-split hold; a new split outranks a release.
    always_comb begin
        split_ev     = hready_i && (hresp_i == RSP_SPLIT) && (data_mst_i != IW'(DUMMY_ID));
        mask_nxt_o   = mask_q & ~{unsplit_i, 1'b0};
        if (split_ev) mask_nxt_o[data_mst_i] = 1'b1;
        lkhold_nxt_o = lkhold_q && mask_nxt_o[lkmst_q];
        lkmst_nxt    = lkmst_q;
        if (split_ev && lock_i[data_mst_i]) begin
            lkhold_nxt_o = 1'b1;
            lkmst_nxt    = data_mst_i;
        end
    end

    // State registers, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            lkhold_q <= 1'b0;
            lkmst_q  <= IW'(DEFAULT_ID);
        end else begin
            mask_q   <= mask_nxt_o;
            lkhold_q <= lkhold_nxt_o;
            lkmst_q  <= lkmst_nxt;
        end
    end
endmodule

// File: rtl/arb_prio_select.sv
// Picks the highest-ranked eligible master from the package ranking.
// With nobody eligible it returns the default master if allowed, else 0.
module arb_prio_select #(
    parameter int NM = arb_pkg::MST_COUNT,
    localparam int IW = $clog2(NM)
) (
    input  logic [NM-1:0] cand_i,
    input  logic          dflt_ok_i,
    output logic [IW-1:0] win_o
);
    import arb_pkg::*;

    // Walk from lowest rank upward so the highest eligible rank is kept.
    always_comb begin
        win_o = dflt_ok_i ? IW'(DEFAULT_ID) : IW'(DUMMY_ID);
        for (int r = NM - 1; r >= 0; r--) begin
            if (cand_i[PRIO_ORDER[r]]) win_o = IW'(PRIO_ORDER[r]);
        end
    end
endmodule

// File: rtl/prio_bus_arbiter.sv
// Fixed-priority arbiter for a shared bus with an idle-only master 0.
// Ownership is re-evaluated only on edges where hready_i is high.
// Assumes external muxes use addr_mst_o / data_mst_o for steering.
module prio_bus_arbiter #(
    parameter int NM = arb_pkg::MST_COUNT,
    localparam int IW = $clog2(NM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NM-1:0] req_i,
    input  logic [NM-1:0] lock_i,
    input  logic [NM-2:0] unsplit_i,
    input  logic          hready_i,
    input  logic [1:0]    hresp_i,
    input  logic [1:0]    htrans_i,
    output logic [NM-1:0] grant_o,
    output logic [IW-1:0] addr_mst_o,
    output logic [IW-1:0] data_mst_o,
    output logic [1:0]    htrans_o
);
    import arb_pkg::*;

    logic [IW-1:0] own_q, dat_q, win, own_nxt;
    logic [NM-1:0] mask_nxt, cand;
    logic          lkhold_nxt, keep_lock;

    arb_split_track #(.NM(NM)) u_split (
        .clk          (clk),
        .rst_n        (rst_n),
        .hready_i     (hready_i),
        .hresp_i      (hresp_i),
        .data_mst_i   (dat_q),
        .lock_i       (lock_i),
        .unsplit_i    (unsplit_i),
        .mask_nxt_o   (mask_nxt),
        .lkhold_nxt_o (lkhold_nxt)
    );

    arb_prio_select #(.NM(NM)) u_sel (
        .cand_i    (cand),
        .dflt_ok_i (!mask_nxt[DEFAULT_ID]),
        .win_o     (win)
    );

    // Decide the next owner: locked-split hold, then lock, then ranking.
    always_comb begin
        cand      = req_i & ~mask_nxt;
        keep_lock = lock_i[own_q] && !mask_nxt[own_q];
        if (lkhold_nxt)     own_nxt = IW'(DUMMY_ID);
        else if (keep_lock) own_nxt = own_q;
        else                own_nxt = win;
    end

    // Address and data phase owners advance together on ready edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= IW'(DEFAULT_ID);
            dat_q <= IW'(DEFAULT_ID);
        end else if (hready_i) begin
            own_q <= own_nxt;
            dat_q <= own_q;
        end
    end

    // One-hot grant decode, one line per master.
    for (genvar g = 0; g < NM; g++) begin : g_grant
        assign grant_o[g] = (own_q == IW'(g));
    end

    assign addr_mst_o = own_q;
    assign data_mst_o = dat_q;
    assign htrans_o   = (own_q == IW'(DUMMY_ID)) ? TRN_IDLE : htrans_i;
endmodule

// File: rtl/prio_bus_arbiter_chk.sv
// Property checker bound to the arbiter; observes ports only.
module prio_bus_arbiter_chk #(
    parameter int NM = arb_pkg::MST_COUNT,
    localparam int IW = $clog2(NM)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hready_i,
    input logic [1:0]    hresp_i,
    input logic [NM-1:0] lock_i,
    input logic [NM-1:0] grant_o,
    input logic [IW-1:0] addr_mst_o,
    input logic [IW-1:0] data_mst_o,
    input logic [1:0]    htrans_o
);
    import arb_pkg::*;

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !hready_i |=> $stable(addr_mst_o) && $stable(data_mst_o));

    assert_pipe_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hready_i |=> data_mst_o == $past(addr_mst_o));

    assert_idle_dummy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o[DUMMY_ID] |-> htrans_o == TRN_IDLE);

    assert_split_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hready_i && hresp_i == RSP_SPLIT && data_mst_o != IW'(DUMMY_ID)
        |=> addr_mst_o != $past(data_mst_o));

    assert_lock_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hready_i && lock_i[addr_mst_o] && hresp_i != RSP_SPLIT
        |=> addr_mst_o == $past(addr_mst_o));

    assert_grant_onehot_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) == 1);
endmodule

bind prio_bus_arbiter prio_bus_arbiter_chk #(.NM(NM)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hready_i   (hready_i),
    .hresp_i    (hresp_i),
    .lock_i     (lock_i),
    .grant_o    (grant_o),
    .addr_mst_o (addr_mst_o),
    .data_mst_o (data_mst_o),
    .htrans_o   (htrans_o)
);

// File: tb/test_prio_bus_arbiter.sv
// Bench: vector table walked by one loop, then directed reset test.
module test_prio_bus_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_i = '0, lock_i = '0, grant_o;
    logic [2:0] unsplit_i = '0;
    logic       hready_i = 1'b1;
    logic [1:0] hresp_i = 2'b00, htrans_i = 2'b10, htrans_o, addr_mst_o, data_mst_o;
    int checks = 0, failures = 0;

    always #2 clk = ~clk;  // 250 MHz

    prio_bus_arbiter i_prio_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .lock_i(lock_i),
        .unsplit_i(unsplit_i), .hready_i(hready_i), .hresp_i(hresp_i),
        .htrans_i(htrans_i), .grant_o(grant_o), .addr_mst_o(addr_mst_o),
        .data_mst_o(data_mst_o), .htrans_o(htrans_o)
    );

    // {tag, req, lock, ready, resp, unsplit, exp_addr, exp_data}
    localparam int NV = 32;
    localparam logic [21:0] VEC [NV] = '{
        {4'd3,  4'b0000, 4'b0000, 1'b1, 2'b00, 3'b000, 2'd1, 2'd1}, // R3 default
        {4'd2,  4'b0110, 4'b0000, 1'b1, 2'b00, 3'b000, 2'd2, 2'd1}, // R2
        {4'd2,  4'b1111, 4'b0000, 1'b1, 2'b00, 3'b000, 2'd3, 2'd2}, // R2
        {4'd2,  4'b0111, 4'b0000, 1'b1, 2'b00, 3'b000, 2'd0, 2'd3}, // R2 pause over 2
        {4'd5,  4'b0110, 4'b0000, 1'b0, 2'b00, 3'b000, 2'd0, 2'd3}, // R5 stall
        {4'd6,  4'b0110, 4'b0000, 1'b1, 2'b00, 3'b000, 2'd2, 2'd0}, // R6
        {4'd7,  4'b0110, 4'b0000, 1'b1, 2'b01, 3'b000, 2'd2, 2'd2}, // R7 error no mask
        {4'd7,  4'b0110, 4'b0000, 1'b1, 2'b11, 3'b000, 2'd1, 2'd2}, // R7 split m2
        {4'd7,  4'b0100, 4'b0000, 1'b1, 2'b10, 3'b000, 2'd1, 2'd1}, // R7 still masked
        {4'd7,  4'b0100, 4'b0000, 1'b1, 2'b00, 3'b010, 2'd2, 2'd1}, // R7 unsplit m2
        {4'd8,  4'b0100, 4'b0100, 1'b1, 2'b00, 3'b000, 2'd2, 2'd2}, // R8
        {4'd8,  4'b1100, 4'b0100, 1'b1, 2'b00, 3'b000, 2'd2, 2'd2}, // R8 lock beats m3
        {4'd9,  4'b1100, 4'b0100, 1'b1, 2'b11, 3'b000, 2'd0, 2'd2}, // R9 locked split
        {4'd9,  4'b1000, 4'b0000, 1'b1, 2'b00, 3'b000, 2'd0, 2'd0}, // R9 held
        {4'd9,  4'b1000, 4'b0000, 1'b1, 2'b00, 3'b010, 2'd3, 2'd0}, // R9 released
        {4'd3,  4'b0000, 4'b0000, 1'b1, 2'b00, 3'b000, 2'd1, 2'd3}, // R3
        {4'd6,  4'b0000, 4'b0000, 1'b1, 2'b00, 3'b000, 2'd1, 2'd1}, // R6
        {4'd10, 4'b0000, 4'b0000, 1'b1, 2'b11, 3'b000, 2'd0, 2'd1}, // R10
        {4'd10, 4'b0000, 4'b0000, 1'b1, 2'b00, 3'b000, 2'd0, 2'd0}, // R10 held
        {4'd7,  4'b0000, 4'b0000, 1'b1, 2'b00, 3'b001, 2'd1, 2'd0}, // R7 unsplit m1
        {4'd2,  4'b1000, 4'b0000, 1'b1, 2'b00, 3'b000, 2'd3, 2'd1}, // R2
        {4'd6,  4'b1000, 4'b0000, 1'b1, 2'b00, 3'b000, 2'd3, 2'd3}, // R6
        {4'd7,  4'b1100, 4'b0000, 1'b1, 2'b11, 3'b000, 2'd2, 2'd3}, // R7 split m3
        {4'd6,  4'b1100, 4'b0000, 1'b1, 2'b00, 3'b000, 2'd2, 2'd2}, // R6
        {4'd7,  4'b1100, 4'b0000, 1'b1, 2'b11, 3'b000, 2'd1, 2'd2}, // R7 split m2
        {4'd6,  4'b1110, 4'b0000, 1'b1, 2'b00, 3'b000, 2'd1, 2'd1}, // R6
        {4'd11, 4'b1110, 4'b0000, 1'b1, 2'b11, 3'b000, 2'd0, 2'd1}, // R11 all split
        {4'd7,  4'b1110, 4'b0000, 1'b1, 2'b00, 3'b100, 2'd3, 2'd0}, // R7 unsplit m3
        {4'd6,  4'b1110, 4'b0000, 1'b1, 2'b00, 3'b000, 2'd3, 2'd3}, // R6
        {4'd12, 4'b1110, 4'b0000, 1'b1, 2'b11, 3'b100, 2'd0, 2'd3}, // R12 split wins
        {4'd12, 4'b1110, 4'b0000, 1'b1, 2'b00, 3'b000, 2'd0, 2'd0}, // R12 mask kept
        {4'd7,  4'b1110, 4'b0000, 1'b1, 2'b00, 3'b111, 2'd3, 2'd0}  // R7 free all
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare all outputs with the expected owners (R4, R13 derived).
    task automatic check_outs(input int tag, input int ea, input int ed);
        check($sformatf("R%0d addr_mst", tag), int'(addr_mst_o), ea);
        check($sformatf("R%0d data_mst", tag), int'(data_mst_o), ed);
        check("R13 grant", int'(grant_o), 1 << ea);
        check("R4 htrans", int'(htrans_o), (ea == 0) ? 0 : int'(htrans_i));
    endtask

    task automatic step(input logic [3:0] rq, input logic [3:0] lk, input logic rdy,
                        input logic [1:0] rsp, input logic [2:0] us);
        req_i = rq; lock_i = lk; hready_i = rdy; hresp_i = rsp; unsplit_i = us;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_outs(1, 1, 1);  // R1 state after reset
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][17:14], VEC[i][13:10], VEC[i][9], VEC[i][8:7], VEC[i][6:4]);
            check_outs(int'(VEC[i][21:18]), int'(VEC[i][3:2]), int'(VEC[i][1:0]));
        end
        // R1: mask master 1 so master 0 owns the bus, then reset.
        step(4'b0000, 4'b0000, 1'b1, 2'b00, 3'b000);
        step(4'b0000, 4'b0000, 1'b1, 2'b00, 3'b000);
        step(4'b0000, 4'b0000, 1'b1, 2'b11, 3'b000);
        check_outs(10, 0, 1);
        rst_n = 1'b0;
        step(4'b0000, 4'b0000, 1'b1, 2'b00, 3'b000);
        check_outs(1, 1, 1);
        rst_n = 1'b1;
        step(4'b0000, 4'b0000, 1'b1, 2'b00, 3'b000);
        check_outs(1, 1, 1);  // R1 mask cleared, default owns
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule